// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog that counts a slow free-running tick and raises a one-cycle reset pulse when it expires. It owns no divider of its own. A single divide chain is shared with a general-purpose timer, and one ownership input decides which of the two uses it. When the watchdog owns the chain, each overflow of the watchdog base counter feeds the chain, and a three-bit select picks one of eight taps to decide which overflow becomes the timeout. When the timer owns the chain, the watchdog times out on every base overflow, and the timer's count source passes through the chain before it reaches the timer.

Software keeps the watchdog quiet with a kick strobe. The strobe zeroes the base counter, and it also zeroes the shared chain when the watchdog owns it, but it never alters ownership. Any change of ownership flushes the chain, so that a partial count left by one owner is never inherited by the other. A configuration enable gates the whole watchdog path.

All logic runs on one system clock. The tick, the timer source and the kick are single-cycle enable strobes in that clock domain.

Top module: `wdt_shared_prescaler`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `wd_reset` and `tmr_clk` are 0, and the base counter, the divide chain and the stored owner (timer) are cleared.
- R2: With `wd_enable` high, each `wd_tick` advances the BASE_W-bit base counter by one, wrapping to zero; a tick that finds the counter at its all-ones value is a base overflow.
- R3: With `pre_to_wd` = 0 (timer owns the chain), every base overflow raises `wd_reset`, and `tmr_clk` pulses on one of every 2^`pre_sel` `tmr_src` strobes.
- R4: With `pre_to_wd` = 1 (watchdog owns the chain), `tmr_clk` repeats `tmr_src` undivided, and `wd_reset` pulses on one of every 2^`pre_sel` base overflows.
- R5: Select value k (0 to 7) picks a ratio of 1:2^k; the tap fires on the event that finds the low k chain bits all ones, so the first output of a cleared chain is its 2^k-th input event.
- R6: `wd_kick` zeroes the base counter and takes priority over a tick in the same cycle (no increment, no overflow); it zeroes the chain only when `pre_to_wd` = 1, and with `pre_to_wd` = 0 the timer's chain count is kept.
- R7: With `wd_enable` low, `wd_reset` stays 0 and the base counter is held at zero.
- R8: A timeout is a single-cycle `wd_reset` pulse, registered one clock after the edge that sees the overflow; after it the base counter and a watchdog-owned chain start again from zero.
- R9: In a cycle where `pre_to_wd` differs from its value in the previous cycle, the chain is cleared, counts no event and its taps stay silent for that cycle.
- R10: Both outputs are registered: each reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_tick | input | 1 | Free-running watchdog tick strobe |
| tmr_src | input | 1 | Count strobe from the general timer's source |
| wd_enable | input | 1 | Configuration enable for the watchdog |
| pre_to_wd | input | 1 | Chain ownership: 1 watchdog, 0 timer |
| pre_sel | input | 3 | Tap select, ratio 1:2^pre_sel |
| wd_kick | input | 1 | Clear-watchdog strobe |
| wd_reset | output | 1 | One-cycle timeout reset pulse |
| tmr_clk | output | 1 | Count strobe delivered to the general timer |

## Verification
The bench builds the block with a 4-bit base counter and the default eight-tap chain. The narrow base counter makes an overflow every sixteen ticks, so every tap up to 1:128 completes several timeouts under watchdog ownership within a few thousand cycles, and kicks, enable drops and ownership flips land near overflows and partial chain counts often enough to exercise the priority and flush rules.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  // Owner of the shared divide chain
  typedef enum logic {
    OWN_TIMER = 1'b0,
    OWN_WDT   = 1'b1
  } owner_e;

endpackage

// File: rtl/wdp_base_cnt.sv
module wdp_base_cnt #(
  parameter int BASE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic kick,
  output logic ovf
);

  localparam logic [BASE_W-1:0] TOP_VAL = {BASE_W{1'b1}};

  logic [BASE_W-1:0] cnt;

  // Overflow: a tick that finds the counter at its top value, kick wins
  assign ovf = en & tick & ~kick & (cnt == TOP_VAL);

  always_ff @(posedge clk) begin
    if (rst || !en || kick) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_kick_zero_r6: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0));

  p_off_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0));

endmodule

// File: rtl/wdp_prescaler.sv
module wdp_prescaler #(
  parameter int TAPS  = 8,
  parameter int SEL_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic             flush,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);

  localparam int CNT_W = TAPS - 1;

  logic [CNT_W-1:0] pcnt;
  logic [TAPS-1:0]  tap;

  // Tap k fires on the event that finds the low k chain bits all ones
  assign tap[0] = ev;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap[k] = ev & (&pcnt[k-1:0]);
  end

  assign fire = tap[sel];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pcnt <= '0;
    end else if (ev) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pcnt == '0));

  p_fire_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    fire |-> ev);

endmodule

// File: rtl/wdp_steer.sv
module wdp_steer
  import wdp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  owner_e owner,
  input  logic   swap,
  input  logic   en,
  input  logic   kick,
  input  logic   ovf,
  input  logic   fire,
  input  logic   tmr_src,
  output logic   pev,
  output logic   flush,
  output logic   wd_reset,
  output logic   tmr_clk
);

  logic own_wd;
  logic tmo;
  logic tclk_d;

  assign own_wd = (owner == OWN_WDT);

  // Chain input: watchdog overflow or timer source, silent on a swap cycle
  assign pev    = ~swap & (own_wd ? ovf : tmr_src);
  assign tmo    = en & (own_wd ? fire : ovf);
  assign tclk_d = own_wd ? tmr_src : fire;
  assign flush  = swap | (own_wd & (kick | fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_reset <= 1'b0;
      tmr_clk  <= 1'b0;
    end else begin
      wd_reset <= tmo;
      tmr_clk  <= tclk_d;
    end
  end

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    wd_reset |=> !wd_reset);

  p_off_no_reset_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wd_reset);

  p_direct_timer_r4: assert property (@(posedge clk) disable iff (rst)
    own_wd |=> (tmr_clk == $past(tmr_src)));

  p_direct_wdt_r3: assert property (@(posedge clk) disable iff (rst)
    (!own_wd && ovf) |=> wd_reset);

endmodule

// File: rtl/wdt_shared_prescaler.sv
module wdt_shared_prescaler
  import wdp_pkg::*;
#(
  parameter int  BASE_W = 8,
  parameter int  TAPS   = 8,
  localparam int SEL_W  = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_tick,
  input  logic             tmr_src,
  input  logic             wd_enable,
  input  logic             pre_to_wd,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic             wd_kick,
  output logic             wd_reset,
  output logic             tmr_clk
);

  owner_e owner_now;
  owner_e owner_q;
  logic   swap;
  logic   ovf;
  logic   pev;
  logic   flush;
  logic   fire;

  assign owner_now = owner_e'(pre_to_wd);
  assign swap      = (owner_now != owner_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_TIMER;
    end else begin
      owner_q <= owner_now;
    end
  end

  wdp_base_cnt #(
    .BASE_W(BASE_W)
  ) i_base (
    .clk (clk),
    .rst (rst),
    .en  (wd_enable),
    .tick(wd_tick),
    .kick(wd_kick),
    .ovf (ovf)
  );

  wdp_prescaler #(
    .TAPS (TAPS),
    .SEL_W(SEL_W)
  ) i_pre (
    .clk  (clk),
    .rst  (rst),
    .ev   (pev),
    .flush(flush),
    .sel  (pre_sel),
    .fire (fire)
  );

  wdp_steer i_steer (
    .clk     (clk),
    .rst     (rst),
    .owner   (owner_now),
    .swap    (swap),
    .en      (wd_enable),
    .kick    (wd_kick),
    .ovf     (ovf),
    .fire    (fire),
    .tmr_src (tmr_src),
    .pev     (pev),
    .flush   (flush),
    .wd_reset(wd_reset),
    .tmr_clk (tmr_clk)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wd_reset && !tmr_clk));

  p_swap_no_timer_r9: assert property (@(posedge clk) disable iff (rst)
    (swap && !pre_to_wd) |=> !tmr_clk);

endmodule

// File: tb/test_wdt_shared_prescaler.sv
module test_wdt_shared_prescaler;

  localparam int BW    = 4;
  localparam int TP    = 8;
  localparam int SW    = 3;
  localparam int LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wd_tick = 1'b0;
  logic          tmr_src = 1'b0;
  logic          wd_enable = 1'b0;
  logic          pre_to_wd = 1'b0;
  logic [SW-1:0] pre_sel = '0;
  logic          wd_kick = 1'b0;
  logic          wd_reset;
  logic          tmr_clk;

  int    errors = 0;
  int    checks = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  // Reference model state
  int m_base = 0;
  int m_pre  = 0;
  bit m_own_q = 1'b0;
  bit e_rst = 1'b0;
  bit e_tclk = 1'b0;
  int rst_seen = 0;

  always #4 clk = ~clk;

  wdt_shared_prescaler #(
    .BASE_W(BW),
    .TAPS  (TP)
  ) i_wdt_shared_prescaler (
    .clk      (clk),
    .rst      (rst),
    .wd_tick  (wd_tick),
    .tmr_src  (tmr_src),
    .wd_enable(wd_enable),
    .pre_to_wd(pre_to_wd),
    .pre_sel  (pre_sel),
    .wd_kick  (wd_kick),
    .wd_reset (wd_reset),
    .tmr_clk  (tmr_clk)
  );

  // Behavioural model of the requirements, evaluated at each rising edge
  always @(posedge clk) begin
    bit swap, ovf, pev, fire;
    int ratio;
    cyc = cyc + 1;
    if (rst) begin
      m_base = 0; m_pre = 0; m_own_q = 1'b0; e_rst = 1'b0; e_tclk = 1'b0;
    end else begin
      ratio = 1 << pre_sel;
      swap  = (pre_to_wd != m_own_q);
      ovf   = wd_enable && wd_tick && !wd_kick && (m_base == (1 << BW) - 1);
      if (!wd_enable || wd_kick) m_base = 0;
      else if (wd_tick) m_base = (m_base + 1) % (1 << BW);
      pev   = !swap && (pre_to_wd ? ovf : tmr_src);
      fire  = pev && ((m_pre % ratio) == ratio - 1);
      e_rst  = wd_enable && (pre_to_wd ? fire : ovf);
      e_tclk = pre_to_wd ? tmr_src : fire;
      if (swap || (pre_to_wd && (wd_kick || fire))) m_pre = 0;
      else if (pev) m_pre = (m_pre + 1) % (1 << (TP - 1));
      m_own_q = pre_to_wd;
    end
  end

  // Compare away from the active edge (R10: one-cycle registered outputs)
  always @(negedge clk) begin
    checks = checks + 1;
    if (wd_reset !== e_rst || tmr_clk !== e_tclk) begin
      errors = errors + 1;
      $display("FAIL %s R10: wd_reset=%0b exp %0b, tmr_clk=%0b exp %0b (cycle %0d)",
               cur_req, wd_reset, e_rst, tmr_clk, e_tclk, cyc);
    end
    if (wd_reset === 1'b1) rst_seen = rst_seen + 1;
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog all requirements: cycles=%0d exp below %0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drive(input int n, input bit own, input int sel, input bit en,
                       input int tick_pct, input int src_pct, input int kick_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pre_to_wd = own;
      pre_sel   = SW'(sel);
      wd_enable = en;
      wd_tick   = ($urandom_range(99) < tick_pct);
      tmr_src   = ($urandom_range(99) < src_pct);
      wd_kick   = ($urandom_range(99) < kick_pct);
    end
  endtask

  task automatic expect_count(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      errors = errors + 1;
      $display("FAIL %s: timeouts=%0d exp %0d", req, got, exp);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks = checks + 1;
    if (wd_reset !== 1'b0 || tmr_clk !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R1: wd_reset=%0b tmr_clk=%0b exp 0 0", wd_reset, tmr_clk);
    end

    // R2 R3: timer owns the chain, every overflow times out
    cur_req = "R2 R3";
    rst_seen = 0;
    drive(1, 1'b0, 2, 1'b1, 0, 0, 0);
    drive(16 * 5, 1'b0, 2, 1'b1, 100, 50, 0);
    drive(2, 1'b0, 2, 1'b1, 0, 0, 0);
    expect_count("R2 R3", rst_seen, 5);

    // R3 R5: every tap with a steady timer source
    for (int s = 0; s < TP; s++) begin
      cur_req = "R3 R5";
      drive(150, 1'b0, s, 1'b1, 60, 100, 0);
    end

    // R4 R5 R8: watchdog owns the chain, each tap, full ticks
    for (int s = 0; s < TP; s++) begin
      cur_req = "R4 R5 R8";
      drive(3, 1'b1, s, 1'b1, 0, 30, 1);
      rst_seen = 0;
      drive(16 * (1 << s) * 2, 1'b1, s, 1'b1, 100, 30, 0);
      drive(2, 1'b1, s, 1'b1, 0, 30, 0);
      expect_count("R4 R5 R8", rst_seen, 2);
    end

    // R6: kicks under both owners
    cur_req = "R6";
    drive(2000, 1'b1, 1, 1'b1, 70, 40, 5);
    drive(2000, 1'b0, 3, 1'b1, 70, 60, 5);
    rst_seen = 0;
    drive(300, 1'b1, 0, 1'b1, 100, 40, 100);
    expect_count("R6", rst_seen, 0);

    // R7: watchdog disabled
    cur_req = "R7";
    rst_seen = 0;
    drive(600, 1'b1, 0, 1'b0, 100, 50, 0);
    drive(600, 1'b0, 0, 1'b0, 100, 50, 0);
    expect_count("R7", rst_seen, 0);

    // R9: ownership flips at random points
    cur_req = "R9";
    for (int k = 0; k < 60; k++) begin
      drive($urandom_range(40, 1), k[0], $urandom_range(3), 1'b1, 90, 70, 1);
    end

    cur_req = "R10";
    drive(500, 1'b1, 2, 1'b1, 50, 50, 2);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule